// File: doc/BRIEF.md
# Window Watchdog Timer With Activation Code

This block watches over software with a free-running counter that must be restarted at regular intervals. The counter counts clock cycles. The overflow interval is a power of two, from 2^9 to 2^16 cycles, and software picks it through a byte-wide register port. Software restarts the counter by writing an activation code. There are two code schemes, picked by a static strap. In fixed mode the code is always 0xAC. In variable mode the code is 0xAC minus a reference byte that the block publishes, taken modulo 256. The reference byte changes to a new pseudo-random value after each accepted refresh.

A refresh only counts inside a window at the end of the interval. The window opens at 0, 25, 50 or 75 percent of the interval. The block raises an error in four cases: a refresh that comes too early, a wrong code, a write to the refresh register of the other scheme, and an interval that ends without a refresh. Depending on the error mode, an error gives either a one-cycle reset request or a sticky interrupt flag.

A second strap enables the whole watchdog. The mode register locks at the first accepted refresh. An optional one-cycle pulse marks the moment the window opens.

Top module: `wwd_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rst_req`, `err_irq` and `win_irq` are low. The mode register reads 0x00 and the reference register reads the seed 0x5A.
- R2: In fixed mode (`varcode_strap`=0), writing 0xAC to offset 0x0 while the window is open restarts the counter from zero. No error is raised. The next overflow comes one full interval later.
- R3: The mode register at offset 0xC holds the overflow select OVF in bits 6:4. If no refresh comes, an error is raised when the counter reaches 2^(9+OVF)-1, which is 2^(9+OVF) cycles after the counter starts. The counter then restarts from zero.
- R4: Mode bits 1:0 select the window start WS. The window opens when the counter reaches WS×2^(9+OVF)/4. A correct code written while the counter is below that value is an error.
- R5: Any of the following writes is an error while the watchdog is enabled: a code other than the expected one, a write to offset 0x4 in fixed mode, or a write to offset 0x0 in variable mode.
- R6: In variable mode (`varcode_strap`=1), writing (0xAC − reference) mod 256 to offset 0x4 inside the window is an accepted refresh.
- R7: The reference register at offset 0x8 changes only on an accepted refresh. Its next value is {ref[6:0], ref[7]^ref[5]^ref[4]^ref[3]}.
- R8: Mode bit 2 selects the error mode. When it is 0, each error gives a one-cycle `rst_req` pulse on the cycle after the error. When it is 1, each error sets `err_irq`, which then stays high until reset.
- R9: When mode bit 3 is set, `win_irq` pulses for one cycle on the cycle after the counter equals the window start.
- R10: While `en_strap` is low, the counter stays at zero, writes to offsets 0x0 and 0x4 have no effect, and no error is raised.
- R11: Writes to offset 0xC change the mode only until the first accepted refresh after reset. Later writes there are ignored.
- R12: `rdata` is registered and shows, one cycle after `addr` is presented, the reference byte (0x8), the mode byte with bit 7 reading 0 (0xC), or zero for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| en_strap | input | 1 | Static watchdog enable |
| varcode_strap | input | 1 | Static select of variable-code mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on error (error mode 0) |
| err_irq | output | 1 | Sticky error flag (error mode 1) |
| win_irq | output | 1 | One-cycle pulse when the window opens |

## Verification
The refresh is tried with several patterns, and each one isolates a separate decision of the block. A correct code inside the window must be accepted, the same code too early must be rejected, a wrong value must be rejected, and a write to the other scheme's register must be rejected. A bench model predicts every output on every cycle, so a window boundary or an overflow that lands even one cycle off is caught. Variable mode is run across a change of the reference byte, which separates a code derived from the current reference from one derived from a stale reference. Running with the watchdog disabled, with a later mode write after the lock, and with both error modes covers gating, locking and how errors are reported.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  // register offsets (refresh, variable refresh, reference, mode)
  localparam logic [3:0] OFF_FIX  = 4'h0;
  localparam logic [3:0] OFF_VAR  = 4'h4;
  localparam logic [3:0] OFF_REF  = 4'h8;
  localparam logic [3:0] OFF_MODE = 4'hC;

  // mode byte field positions
  localparam int MODE_W      = 7;
  localparam int M_OVF_LO    = 4;
  localparam int M_WIE       = 3;
  localparam int M_ERRMODE   = 2;
  localparam int M_WS_LO     = 0;

  localparam logic [7:0] ACT_CODE = 8'hAC;
endpackage

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int BASE_LOG2 = 9,
  parameter int OVF_W     = 3,
  parameter int CNT_W     = BASE_LOG2 + (1 << OVF_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [OVF_W-1:0] ovf,
  input  logic [1:0]       ws,
  output logic             at_last,
  output logic             at_start,
  output logic             win_open
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   quarter;
  logic [CNT_W:0]   starts [4];
  logic [CNT_W:0]   wstart;
  logic [CNT_W-1:0] last;

  always_comb begin
    span    = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG2 + int'(ovf));
    quarter = span >> 2;
    last    = span[CNT_W-1:0] - 1'b1;
  end

  // one candidate window start per encoding
  for (genvar g = 0; g < 4; g++) begin : g_start
    assign starts[g] = quarter * (CNT_W+1)'(g);
  end

  assign wstart   = starts[ws];
  assign at_last  = (cnt_q == last);
  assign at_start = ({1'b0, cnt_q} == wstart);
  assign win_open = ({1'b0, cnt_q} >= wstart);

  always_ff @(posedge clk) begin
    if (rst || !run)         cnt_q <= '0;
    else if (clear || at_last) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wwd_code_check.sv
module wwd_code_check #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              varmode,
  input  logic [DATA_W-1:0] ref_val,
  input  logic              win_open,
  output logic              refresh_ok,
  output logic              code_err
);
  import wwd_pkg::*;

  logic              hit_fix, hit_var;
  logic [DATA_W-1:0] var_code;

  assign hit_fix  = wr_en && (addr == ADDR_W'(OFF_FIX));
  assign hit_var  = wr_en && (addr == ADDR_W'(OFF_VAR));
  assign var_code = DATA_W'(ACT_CODE) - ref_val;

  always_comb begin
    refresh_ok = 1'b0;
    code_err   = 1'b0;
    if (hit_fix) begin
      if (varmode || wdata != DATA_W'(ACT_CODE) || !win_open) code_err = 1'b1;
      else refresh_ok = 1'b1;
    end else if (hit_var) begin
      if (!varmode || wdata != var_code || !win_open) code_err = 1'b1;
      else refresh_ok = 1'b1;
    end
  end
endmodule

// File: rtl/wwd_lfsr.sv
module wwd_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/wwd_top.sv
module wwd_top #(
  parameter int         ADDR_W    = 4,
  parameter int         DATA_W    = 8,
  parameter int         BASE_LOG2 = 9,
  parameter int         OVF_W     = 3,
  parameter logic [7:0] REF_SEED  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_strap,
  input  logic              varcode_strap,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              err_irq,
  output logic              win_irq
);
  import wwd_pkg::*;

  localparam int CNT_W = BASE_LOG2 + (1 << OVF_W) - 1;

  logic [MODE_W-1:0] mode_q;
  logic              locked_q;
  logic [DATA_W-1:0] ref_q;
  logic              at_last, at_start, win_open;
  logic              refresh_ok, code_err;
  logic              refresh, fault;

  wire [OVF_W-1:0] m_ovf  = mode_q[M_OVF_LO +: OVF_W];
  wire [1:0]       m_ws   = mode_q[M_WS_LO +: 2];
  wire             m_wie  = mode_q[M_WIE];
  wire             m_emod = mode_q[M_ERRMODE];

  wwd_counter #(.BASE_LOG2(BASE_LOG2), .OVF_W(OVF_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(en_strap), .clear(refresh | fault),
    .ovf(m_ovf), .ws(m_ws),
    .at_last(at_last), .at_start(at_start), .win_open(win_open)
  );

  wwd_code_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_code (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .varmode(varcode_strap),
    .ref_val(ref_q), .win_open(win_open),
    .refresh_ok(refresh_ok), .code_err(code_err)
  );

  wwd_lfsr #(.W(DATA_W), .TAPS(DATA_W'(8'hB8)), .SEED(DATA_W'(REF_SEED))) u_lfsr (
    .clk(clk), .rst(rst), .adv(refresh), .q(ref_q)
  );

  assign refresh = en_strap && refresh_ok;
  assign fault   = en_strap && (code_err || (at_last && !refresh_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      locked_q <= 1'b0;
      rst_req  <= 1'b0;
      err_irq  <= 1'b0;
      win_irq  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(OFF_MODE) && !locked_q)
        mode_q <= wdata[MODE_W-1:0];
      if (refresh) locked_q <= 1'b1;
      rst_req <= fault && !m_emod;
      if (fault && m_emod) err_irq <= 1'b1;
      win_irq <= en_strap && m_wie && at_start;
      if (addr == ADDR_W'(OFF_REF))       rdata <= ref_q;
      else if (addr == ADDR_W'(OFF_MODE)) rdata <= DATA_W'(mode_q);
      else                                rdata <= '0;
    end
  end
endmodule

// File: rtl/wwd_top_chk.sv
module wwd_top_chk #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              en_strap,
  input logic              rst_req,
  input logic              err_irq,
  input logic              win_irq,
  input logic              locked,
  input logic [MODE_W-1:0] mode_bits,
  input logic [DATA_W-1:0] ref_val
);
  // R8: the sticky flag never falls outside reset
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_irq |=> err_irq);

  // R8: a reset request only comes from error mode 0
  p_req_mode0_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(mode_bits[2]));

  // R10: a disabled watchdog raises nothing on the next cycle
  p_quiet_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en_strap |=> (!rst_req && !$rose(err_irq) && !win_irq));

  // R11: once locked, the mode holds
  p_mode_lock_r11: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(mode_bits));

  // R9: a window pulse needs the enable bit
  p_win_gate_r9: assert property (@(posedge clk) disable iff (rst)
    win_irq |-> $past(mode_bits[3]));

  // R7: the reference moves only together with an accepted refresh
  p_ref_move_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_val) |-> locked);
endmodule

bind wwd_top wwd_top_chk #(.DATA_W(DATA_W), .MODE_W(wwd_pkg::MODE_W)) u_wwd_chk (
  .clk(clk), .rst(rst), .en_strap(en_strap), .rst_req(rst_req),
  .err_irq(err_irq), .win_irq(win_irq), .locked(locked_q),
  .mode_bits(mode_q), .ref_val(ref_q)
);

// File: tb/sim_wwd_top.sv
module sim_wwd_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_strap = 1'b1;
  logic       varcode_strap = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req, err_irq, win_irq;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;
  int win_seen = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwd_top u0 (
    .clk(clk), .rst(rst), .en_strap(en_strap), .varcode_strap(varcode_strap),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rst_req(rst_req), .err_irq(err_irq), .win_irq(win_irq)
  );

  // ---------------- behavioural reference model ----------------
  int        m_cnt;
  bit        m_lock;
  bit [6:0]  m_mode;
  bit [7:0]  m_ref;
  bit        m_rst, m_irq, m_win;
  bit [7:0]  m_rd;

  function automatic bit [7:0] next_ref(bit [7:0] v);
    bit nb;
    nb = v[7] ^ v[5] ^ v[4] ^ v[3];
    return {v[6:0], nb};
  endfunction

  always @(posedge clk) begin
    int span, wstart;
    bit ok, bad;
    if (rst) begin
      m_cnt = 0; m_lock = 0; m_mode = 0; m_ref = 8'h5A;
      m_rst = 0; m_irq = 0; m_win = 0; m_rd = 0;
    end else begin
      span   = 1 << (9 + int'(m_mode[6:4]));
      wstart = (span / 4) * int'(m_mode[1:0]);
      ok = 0; bad = 0;
      if (en_strap) begin
        if (wr_en && addr == 4'h0) begin
          if (varcode_strap || wdata != 8'hAC || m_cnt < wstart) bad = 1; else ok = 1;
        end
        if (wr_en && addr == 4'h4) begin
          if (!varcode_strap || wdata != 8'(8'hAC - m_ref) || m_cnt < wstart) bad = 1; else ok = 1;
        end
        if (!ok && m_cnt == span - 1) bad = 1;
      end
      m_rd  = (addr == 4'h8) ? m_ref : (addr == 4'hC) ? {1'b0, m_mode} : 8'h00;
      m_win = en_strap && m_mode[3] && (m_cnt == wstart);
      m_rst = bad && !m_mode[2];
      if (bad && m_mode[2]) m_irq = 1;
      if (ok) m_ref = next_ref(m_ref);
      if (wr_en && addr == 4'hC && !m_lock) m_mode = wdata[6:0];
      if (ok) m_lock = 1;
      if (!en_strap || ok || bad) m_cnt = 0; else m_cnt = m_cnt + 1;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      checks++;
      if (rst_req !== m_rst) begin errors++; $display("FAIL R8 rst_req actual %b expected %b at %0t", rst_req, m_rst, $time); end
      checks++;
      if (err_irq !== m_irq) begin errors++; $display("FAIL R8 err_irq actual %b expected %b at %0t", err_irq, m_irq, $time); end
      checks++;
      if (win_irq !== m_win) begin errors++; $display("FAIL R9 win_irq actual %b expected %b at %0t", win_irq, m_win, $time); end
      checks++;
      if (rdata !== m_rd) begin errors++; $display("FAIL R12 rdata actual %h expected %h at %0t", rdata, m_rd, $time); end
      if (rst_req === 1'b1) rst_seen++;
      if (win_irq === 1'b1) win_seen++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit [3:0] a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit [3:0] a, output bit [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin : stim
    bit [7:0] v, r0;
    int base;
    do_reset();
    cmp_on = 1;
    // R1 reset state
    check(rst_req == 0 && err_irq == 0 && win_irq == 0, "R1 outputs after reset", {rst_req, err_irq, win_irq}, 0);
    rd(4'h8, v);
    check(v == 8'h5A, "R1 reference seed", v, 8'h5A);
    rd(4'hC, v);
    check(v == 8'h00, "R1 mode cleared", v, 0);

    // fixed mode: ovf=0, wie=1, errmode=0, ws=3 -> 0x0B
    wr(4'hC, 8'h0B);
    idle(390);
    base = rst_seen;
    wr(4'h0, 8'hAC);                         // R2 in-window refresh
    rd(4'h8, v);
    check(v == next_ref(8'h5A), "R7 reference advanced", v, next_ref(8'h5A));
    idle(300);
    check(rst_seen == base, "R2 refresh restarted counter", rst_seen, base);
    check(win_seen > 0, "R9 window pulse seen", win_seen, 1);
    wr(4'hC, 8'h7F);                         // R11 ignored after lock
    rd(4'hC, v);
    check(v == 8'h0B, "R11 mode locked", v, 8'h0B);
    idle(100);
    wr(4'h0, 8'hAC);
    check(rst_seen == base, "R2 second refresh accepted", rst_seen, base);

    idle(10);
    wr(4'h0, 8'hAC);                         // R4 too early
    idle(2);
    check(rst_seen == base + 1, "R4 early refresh is error", rst_seen, base + 1);
    idle(400);
    wr(4'h0, 8'h55);                         // R5 wrong code
    idle(2);
    check(rst_seen == base + 2, "R5 wrong code error", rst_seen, base + 2);
    idle(400);
    wr(4'h4, 8'hAC);                         // R5 other-mode register
    idle(2);
    check(rst_seen == base + 3, "R5 variable register in fixed mode", rst_seen, base + 3);
    idle(600);                               // R3 overflow after 512 cycles
    check(rst_seen == base + 4, "R3 overflow error", rst_seen, base + 4);

    // variable mode: ovf=1, wie=1, errmode=1, ws=2 -> 0x1E
    varcode_strap = 1'b1;
    do_reset();
    wr(4'hC, 8'h1E);
    rd(4'h8, r0);
    idle(600);
    base = rst_seen;
    wr(4'h4, 8'(8'hAC - r0));                // R6 accepted
    idle(2);
    check(err_irq == 0, "R6 variable code accepted", err_irq, 0);
    rd(4'h8, v);
    check(v == next_ref(r0), "R7 reference next value", v, next_ref(r0));
    idle(600);
    wr(4'h4, 8'(8'hAC - r0));                // stale code now wrong
    idle(2);
    check(err_irq == 1, "R8 sticky flag on error", err_irq, 1);
    check(rst_seen == base, "R8 no reset request in mode 1", rst_seen, base);
    idle(50);
    check(err_irq == 1, "R8 flag stays set", err_irq, 1);
    wr(4'h0, 8'hAC);                         // R5 fixed register in variable mode
    idle(2);
    check(err_irq == 1 && rst_seen == base, "R5 fixed register in variable mode", rst_seen, base);

    // disabled watchdog
    varcode_strap = 1'b0;
    en_strap = 1'b0;
    do_reset();
    base = rst_seen;
    idle(1500);
    wr(4'h0, 8'h55);
    wr(4'h4, 8'h12);
    wr(4'h0, 8'hAC);
    idle(5);
    check(rst_seen == base && err_irq == 0, "R10 no error while disabled", rst_seen, base);
    rd(4'h8, v);
    check(v == 8'h5A, "R10 reference untouched while disabled", v, 8'h5A);
    en_strap = 1'b1;
    idle(520);
    check(rst_seen == base + 1, "R3 overflow after enabling", rst_seen, base + 1);

    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual running expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule